// File: doc/BRIEF.md
# Reader Front-End Power Mode Sequencer

This block controls the low-power states of a contactless reader front end. Software writes three control bits through one write strobe: a power-down request, a standby request and a receiver auto-off enable. From these bits the block drives enables for the oscillator buffer, the internal digital clock buffer and the receiver. It also drives a hold signal that tells the pad logic to keep the digital outputs at their present levels.

Each low-power mode starts on the clock edge that takes the write. Leaving a mode is slower. When software clears a mode bit, the mode stays in force for a fixed number of oscillator clock cycles, and its status bit reads back as 1 for that whole time. The bit then clears by itself. Power-down takes priority over standby. While power-down is in force, a pending standby exit does not count. The digital clock comes back only after every active mode has ended.

Each mode has its own controller with three states. In `M_OFF` the mode is inactive. A write of 1 moves it to `M_ON`, and the mode is active. A write of 0 in `M_ON` moves it to `M_LEAVE`, which starts the exit count. In `M_LEAVE`, a write of 1 is an abort and returns the controller to `M_ON`. When the count reaches its last value without a hold, the controller returns to `M_OFF`.

Top module: `pwr_mode_seq`

## Requirements
- R1: After synchronous reset, `pd_status`, `sb_status`, `rxauto_status` and `io_hold` are 0, and `osc_buf_en`, `dclk_buf_en` and `rx_en` are 1.
- R2: A write with `wr_pd`=1 sets `pd_status` on the edge that takes the write. From that cycle on, `osc_buf_en` and `dclk_buf_en` are 0.
- R3: After a write with `wr_pd`=0 to an active power-down, `pd_status` stays 1 for `PD_EXIT_CYCLES` (default 512) further clock edges. It reads 0 after the last of those edges, and the enables then return.
- R4: A write with `wr_sb`=1 sets `sb_status` on the edge that takes the write. `dclk_buf_en` goes to 0, and `osc_buf_en` stays 1 when no power-down is active.
- R5: After a write with `wr_sb`=0 to an active standby, `sb_status` stays 1 for `SB_EXIT_CYCLES` (default 4) further edges and then clears.
- R6: A write of 1 to a mode bit during its exit countdown aborts the exit. The mode stays active, and a later write of 0 restarts the full count.
- R7: While power-down is in force, the standby exit countdown is frozen. It resumes on the edge after `pd_status` clears, and `dclk_buf_en` returns only after both status bits are 0.
- R8: With `rxauto_status`=1 and no mode active, `rx_en` follows `rx_busy`. With `rxauto_status`=0 and no mode active, `rx_en` is 1.
- R9: `rx_en` is 0 whenever either status bit is 1.
- R10: `io_hold` is 1 exactly while either status bit is 1.
- R11: A write of 0 to a mode bit that is not active has no effect on its status or on the enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-domain clock; drives every register and the exit counts |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the three control bits |
| wr_pd | input | 1 | Power-down request value |
| wr_sb | input | 1 | Standby request value |
| wr_rxauto | input | 1 | Receiver auto-off enable value |
| rx_busy | input | 1 | Receiver in use |
| pd_status | output | 1 | Power-down bit readback, 1 until exit completes |
| sb_status | output | 1 | Standby bit readback, 1 until exit completes |
| rxauto_status | output | 1 | Receiver auto-off bit readback |
| osc_buf_en | output | 1 | Oscillator buffer enable |
| dclk_buf_en | output | 1 | Internal digital clock buffer enable |
| rx_en | output | 1 | Receiver power enable |
| io_hold | output | 1 | Keep digital output pads at present levels |

## Verification
The bench builds the block with its default parameters: a 512-cycle power-down exit and a 4-cycle standby exit. It can therefore measure the real exit lengths edge by edge, both the last cycle with the bit set and the first cycle with it cleared. With both modes active, the 512-cycle wait makes the frozen standby count visible: standby ends exactly four edges after power-down ends, not four edges after its own clear. The short standby exit is also what allows an abort-and-restart in the middle of the countdown to be observed.

// File: rtl/pms_pkg.sv
package pms_pkg;
    typedef enum logic [1:0] {
        M_OFF   = 2'd0,
        M_ON    = 2'd1,
        M_LEAVE = 2'd2
    } mode_state_e;

    localparam int unsigned NUM_MODES = 2;
    localparam int unsigned IDX_PD    = 0;
    localparam int unsigned IDX_SB    = 1;
endpackage

// File: rtl/pms_mode_ctrl.sv
module pms_mode_ctrl
    import pms_pkg::*;
#(
    parameter int unsigned EXIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_val,
    input  logic hold,
    output logic active,
    output logic exiting
);
    localparam int unsigned CW       = $clog2(EXIT_CYCLES + 1);
    localparam logic [CW-1:0] LAST   = CW'(EXIT_CYCLES - 1);

    mode_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            M_OFF: begin
                if (wr_en && wr_val) state_d = M_ON;
            end
            M_ON: begin
                if (wr_en && !wr_val) begin
                    state_d = M_LEAVE;
                    cnt_d   = '0;
                end
            end
            M_LEAVE: begin
                if (wr_en && wr_val) begin
                    state_d = M_ON;
                    cnt_d   = '0;
                end else if (!hold) begin
                    if (cnt_q == LAST) begin
                        state_d = M_OFF;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = M_OFF;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= M_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        active  = (state_q != M_OFF);
        exiting = (state_q == M_LEAVE);
    end

    AST_ENTER_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_val) |=> active); // R2
    AST_NO_EARLY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (active && !exiting) |=> active); // R3
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (exiting && hold && !wr_en) |=> (exiting && $stable(cnt_q))); // R7
    AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (exiting && wr_en && wr_val) |=> (active && !exiting)); // R6
    AST_IDLE_CLEAR_NOP: assert property (@(posedge clk) disable iff (rst)
        (!active && !(wr_en && wr_val)) |=> !active); // R11
endmodule

// File: rtl/pms_rx_gate.sv
module pms_rx_gate (
    input  logic clk,
    input  logic rst,
    input  logic low_power,
    input  logic auto_off,
    input  logic rx_busy,
    output logic rx_en
);
    always_comb begin
        if (low_power)     rx_en = 1'b0;
        else if (auto_off) rx_en = rx_busy;
        else               rx_en = 1'b1;
    end

    AST_RX_ALWAYS_ON: assert property (@(posedge clk) disable iff (rst)
        (!low_power && !auto_off) |-> rx_en); // R8
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int unsigned PD_EXIT_CYCLES = 512,
    parameter int unsigned SB_EXIT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_en,
    input  logic wr_pd,
    input  logic wr_sb,
    input  logic wr_rxauto,
    input  logic rx_busy,
    output logic pd_status,
    output logic sb_status,
    output logic rxauto_status,
    output logic osc_buf_en,
    output logic dclk_buf_en,
    output logic rx_en,
    output logic io_hold
);
    logic [NUM_MODES-1:0] wr_bits;
    logic [NUM_MODES-1:0] mode_active;
    logic [NUM_MODES-1:0] mode_exiting;
    logic [NUM_MODES-1:0] mode_hold;
    logic                 rxauto_q;
    logic                 low_power;

    always_comb begin
        wr_bits[IDX_PD] = wr_pd;
        wr_bits[IDX_SB] = wr_sb;
    end

    // Power-down outranks standby: it freezes the standby exit count.
    always_comb begin
        mode_hold[IDX_PD] = 1'b0;
        mode_hold[IDX_SB] = mode_active[IDX_PD];
    end

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        localparam int unsigned EXIT_N = (g == IDX_PD) ? PD_EXIT_CYCLES : SB_EXIT_CYCLES;
        pms_mode_ctrl #(.EXIT_CYCLES(EXIT_N)) u_ctrl (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en),
            .wr_val  (wr_bits[g]),
            .hold    (mode_hold[g]),
            .active  (mode_active[g]),
            .exiting (mode_exiting[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)        rxauto_q <= 1'b0;
        else if (wr_en) rxauto_q <= wr_rxauto;
    end

    assign low_power = |mode_active;

    pms_rx_gate u_rx (
        .clk       (clk),
        .rst       (rst),
        .low_power (low_power),
        .auto_off  (rxauto_q),
        .rx_busy   (rx_busy),
        .rx_en     (rx_en)
    );

    always_comb begin
        pd_status     = mode_active[IDX_PD];
        sb_status     = mode_active[IDX_SB];
        rxauto_status = rxauto_q;
        osc_buf_en    = !mode_active[IDX_PD];
        dclk_buf_en   = !low_power;
        io_hold       = low_power;
    end

    AST_SB_KEEPS_OSC: assert property (@(posedge clk) disable iff (rst)
        (sb_status && !pd_status) |-> osc_buf_en); // R4
    AST_RX_OFF_LOWPWR: assert property (@(posedge clk) disable iff (rst)
        (pd_status || sb_status) |-> !rx_en); // R9
    AST_DCLK_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(dclk_buf_en) |-> (!pd_status && !sb_status)); // R7
    AST_SB_WAITS_PD: assert property (@(posedge clk) disable iff (rst)
        (mode_exiting[IDX_SB] && pd_status) |=> sb_status); // R7
endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
    localparam int PD_N = 512;
    localparam int SB_N = 4;

    logic clk = 1'b0;
    logic rst;
    logic wr_en, wr_pd, wr_sb, wr_rxauto, rx_busy;
    logic pd_status, sb_status, rxauto_status, osc_buf_en, dclk_buf_en, rx_en, io_hold;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pd(wr_pd), .wr_sb(wr_sb),
        .wr_rxauto(wr_rxauto), .rx_busy(rx_busy), .pd_status(pd_status),
        .sb_status(sb_status), .rxauto_status(rxauto_status),
        .osc_buf_en(osc_buf_en), .dclk_buf_en(dclk_buf_en), .rx_en(rx_en),
        .io_hold(io_hold)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic pd, input logic sb, input logic ra);
        @(negedge clk);
        wr_en = 1'b1; wr_pd = pd; wr_sb = sb; wr_rxauto = ra;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; wr_en = 1'b0; wr_pd = 1'b0; wr_sb = 1'b0; wr_rxauto = 1'b0; rx_busy = 1'b0;
        wait_edges(3);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "pd_status", pd_status, 1'b0);
        chk("R1", "sb_status", sb_status, 1'b0);
        chk("R1", "rxauto", rxauto_status, 1'b0);
        chk("R1", "osc_buf_en", osc_buf_en, 1'b1);
        chk("R1", "dclk_buf_en", dclk_buf_en, 1'b1);
        chk("R1", "rx_en", rx_en, 1'b1);
        chk("R1", "io_hold", io_hold, 1'b0);
    endtask

    task automatic t_idle_clear();
        wr(1'b0, 1'b0, 1'b0);
        chk("R11", "pd stays 0", pd_status, 1'b0);
        chk("R11", "sb stays 0", sb_status, 1'b0);
        chk("R11", "dclk stays on", dclk_buf_en, 1'b1);
    endtask

    task automatic t_powerdown();
        wr(1'b1, 1'b0, 1'b0);
        chk("R2", "pd_status set", pd_status, 1'b1);
        chk("R2", "osc off", osc_buf_en, 1'b0);
        chk("R2", "dclk off", dclk_buf_en, 1'b0);
        chk("R9", "rx off in pd", rx_en, 1'b0);
        chk("R10", "hold in pd", io_hold, 1'b1);
        wr(1'b0, 1'b0, 1'b0);
        chk("R3", "pd reads 1 after clear", pd_status, 1'b1);
        wait_edges(PD_N - 1);
        chk("R3", "pd 1 at last exit cycle", pd_status, 1'b1);
        chk("R3", "osc still off", osc_buf_en, 1'b0);
        @(negedge clk);
        chk("R3", "pd cleared", pd_status, 1'b0);
        chk("R3", "osc back", osc_buf_en, 1'b1);
        chk("R3", "dclk back", dclk_buf_en, 1'b1);
        chk("R10", "hold released", io_hold, 1'b0);
    endtask

    task automatic t_standby();
        wr(1'b0, 1'b1, 1'b0);
        chk("R4", "sb set", sb_status, 1'b1);
        chk("R4", "dclk off", dclk_buf_en, 1'b0);
        chk("R4", "osc on", osc_buf_en, 1'b1);
        chk("R9", "rx off in sb", rx_en, 1'b0);
        wr(1'b0, 1'b0, 1'b0);
        wait_edges(SB_N - 1);
        chk("R5", "sb 1 at last exit cycle", sb_status, 1'b1);
        @(negedge clk);
        chk("R5", "sb cleared", sb_status, 1'b0);
        chk("R5", "dclk back", dclk_buf_en, 1'b1);
    endtask

    task automatic t_abort();
        wr(1'b0, 1'b1, 1'b0);
        wr(1'b0, 1'b0, 1'b0);
        wait_edges(1);
        wr(1'b0, 1'b1, 1'b0);
        wait_edges(SB_N + 2);
        chk("R6", "abort keeps sb", sb_status, 1'b1);
        wr(1'b0, 1'b0, 1'b0);
        wait_edges(SB_N - 1);
        chk("R6", "full count after restart", sb_status, 1'b1);
        @(negedge clk);
        chk("R6", "sb cleared after restart", sb_status, 1'b0);
    endtask

    task automatic t_priority();
        wr(1'b1, 1'b1, 1'b0);
        chk("R7", "osc off with both", osc_buf_en, 1'b0);
        wr(1'b0, 1'b0, 1'b0);
        wait_edges(PD_N - 1);
        chk("R7", "pd still set", pd_status, 1'b1);
        @(negedge clk);
        chk("R7", "pd cleared", pd_status, 1'b0);
        chk("R7", "sb frozen", sb_status, 1'b1);
        chk("R7", "dclk still off", dclk_buf_en, 1'b0);
        chk("R7", "osc back", osc_buf_en, 1'b1);
        wait_edges(SB_N - 1);
        chk("R7", "sb at last cycle", sb_status, 1'b1);
        @(negedge clk);
        chk("R7", "sb cleared", sb_status, 1'b0);
        chk("R7", "dclk back last", dclk_buf_en, 1'b1);
    endtask

    task automatic t_rxauto();
        rx_busy = 1'b0;
        #1;
        chk("R8", "rx on when auto off", rx_en, 1'b1);
        wr(1'b0, 1'b0, 1'b1);
        chk("R8", "rxauto readback", rxauto_status, 1'b1);
        chk("R8", "rx off when idle", rx_en, 1'b0);
        rx_busy = 1'b1;
        #1;
        chk("R8", "rx on when busy", rx_en, 1'b1);
        wr(1'b0, 1'b1, 1'b1);
        chk("R9", "rx off in sb even if busy", rx_en, 1'b0);
        wr(1'b0, 1'b0, 1'b1);
        wait_edges(SB_N);
        chk("R8", "rx back busy", rx_en, 1'b1);
        wr(1'b0, 1'b0, 1'b0);
        rx_busy = 1'b0;
        #1;
        chk("R8", "rx on auto cleared", rx_en, 1'b1);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_idle_clear();
        t_powerdown();
        t_standby();
        t_abort();
        t_priority();
        t_rxauto();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule